// File: doc/BRIEF.md
# ADC Scan-to-Memory DMA Engine

This block moves every finished analog-to-digital conversion into the on-chip register file without CPU involvement. It also steps the converter through a run of analog inputs. When the converter reports a two-byte result, the engine asks the CPU for the system bus. Once the CPU grants the bus, the engine stores the result in the slot that belongs to that input, then gives the bus back and starts the next conversion.

The scan runs from input 0 up to a configured highest input. Input n owns two consecutive bytes at `base + 2n`, with the high byte first. After the highest input has been stored, the engine returns to input 0 and starts a fresh conversion there. If interrupts are enabled, it also raises a one-cycle interrupt pulse. Software starts the first conversion with a single start pulse.

A conversion-done event can arrive while a transfer still holds the bus. Such an event is held, together with its data, and is serviced as soon as the bus has been released.

Top module: `adc_scan_dma`

## Requirements
- R1: After reset, `bus_req`, `wr_en`, `adc_start` and `irq` are low and `adc_ch` is 0.
- R2: A `scan_start` pulse while the engine is idle drives `adc_ch` to 0 and pulses `adc_start` for one cycle in the next cycle.
- R3: An `adc_done` pulse while idle raises `bus_req` in the next cycle. `wr_en` stays low for as long as `bus_gnt` is low.
- R4: In the cycle after `bus_gnt` is sampled high, `wr_en` is high for exactly two cycles. In the first cycle `wr_addr` is `base + 2n` and `wr_data` is result bits [15:8]. In the second cycle `wr_addr` is `base + 2n + 1` and `wr_data` is result bits [7:0]. Here n is the input whose result is being stored.
- R5: `bus_req` falls in the cycle right after the second byte is written, which is the same cycle in which `wr_en` falls.
- R6: If n is below `cfg_last_ch`, then in the cycle `bus_req` falls `adc_ch` becomes n+1 and `adc_start` pulses for one cycle.
- R7: If n equals or exceeds `cfg_last_ch`, then in that cycle `adc_ch` becomes 0 and `adc_start` pulses. If `cfg_irq_en` is 1, `irq` also pulses for exactly one cycle.
- R8: With `cfg_irq_en` at 0, `irq` stays low at a wrap.
- R9: An `adc_done` that arrives during a transfer is not dropped. `bus_req` is low for exactly one cycle after the release and then rises again. The held result is then written to the slot of the current input.
- R10: Slot addresses are computed modulo 2^ADDR_W, so a slot above the top of the address space wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W | Base address of the slot table |
| cfg_last_ch | input | CH_W | Highest input in the scan |
| cfg_irq_en | input | 1 | Enables the wrap interrupt |
| scan_start | input | 1 | Starts a conversion on input 0 |
| adc_done | input | 1 | Conversion finished, result valid |
| adc_data | input | 2*BYTE_W | Conversion result |
| adc_ch | output | CH_W | Input to convert next |
| adc_start | output | 1 | One-cycle conversion start |
| bus_req | output | 1 | System bus request to the CPU |
| bus_gnt | input | 1 | Bus acknowledge from the CPU |
| wr_en | output | 1 | Register-file write strobe |
| wr_addr | output | ADDR_W | Register-file write address |
| wr_data | output | BYTE_W | Register-file write byte |
| irq | output | 1 | One-cycle wrap interrupt |

## Verification
The assertions rely on three properties of the environment:
- `bus_gnt` is only raised while `bus_req` is high.
- The configuration inputs stay stable during a transfer.
- At most one conversion-done event is outstanding beyond the one being serviced.

The directed tests respect all three. The grant is driven only after the request has been observed, and it is dropped at release. Configuration is changed only while the engine is idle. A second `adc_done` is injected only once per transfer, which mirrors a converter that starts a new conversion only when told to.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_WR_HI = 2'd2,
        ST_WR_LO = 2'd3
    } dma_state_e;

endpackage

// File: rtl/adc_dma_addr_gen.sv
module adc_dma_addr_gen #(
    parameter int ADDR_W = 12,
    parameter int CH_W   = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CH_W-1:0]   ch,
    input  logic              lo_sel,
    output logic [ADDR_W-1:0] addr
);
    // Slot offset is twice the input number; the low byte sits one above.
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = ADDR_W'(ch) << 1;
        addr   = base + offset + ADDR_W'(lo_sel);
    end
endmodule

// File: rtl/adc_dma_ch_seq.sv
module adc_dma_ch_seq #(
    parameter int CH_W = 3
) (
    input  logic [CH_W-1:0] cur,
    input  logic [CH_W-1:0] last,
    output logic [CH_W-1:0] nxt,
    output logic            wrap
);
    always_comb begin
        wrap = (cur >= last);
        nxt  = wrap ? '0 : cur + CH_W'(1);
    end
endmodule

// File: rtl/adc_scan_dma.sv
module adc_scan_dma
    import adc_dma_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CH_W   = 3,
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     cfg_base,
    input  logic [CH_W-1:0]       cfg_last_ch,
    input  logic                  cfg_irq_en,
    input  logic                  scan_start,
    input  logic                  adc_done,
    input  logic [2*BYTE_W-1:0]   adc_data,
    output logic [CH_W-1:0]       adc_ch,
    output logic                  adc_start,
    output logic                  bus_req,
    input  logic                  bus_gnt,
    output logic                  wr_en,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [BYTE_W-1:0]     wr_data,
    output logic                  irq
);
    localparam int RES_W = 2 * BYTE_W;

    typedef struct packed {
        dma_state_e        state;
        logic [CH_W-1:0]   ch;
        logic              start;
        logic              req;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [BYTE_W-1:0] wr_data;
        logic              irq;
        logic [RES_W-1:0]  xfer_data;
        logic              pend;
        logic [RES_W-1:0]  pend_data;
    } dma_regs_t;

    dma_regs_t r_d, r_q;

    logic [ADDR_W-1:0] addr_hi, addr_lo;
    logic [CH_W-1:0]   ch_next;
    logic              ch_wrap;

    adc_dma_addr_gen #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_addr_hi (
        .base   (cfg_base),
        .ch     (r_q.ch),
        .lo_sel (1'b0),
        .addr   (addr_hi)
    );

    adc_dma_addr_gen #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_addr_lo (
        .base   (cfg_base),
        .ch     (r_q.ch),
        .lo_sel (1'b1),
        .addr   (addr_lo)
    );

    adc_dma_ch_seq #(.CH_W(CH_W)) u_seq (
        .cur  (r_q.ch),
        .last (cfg_last_ch),
        .nxt  (ch_next),
        .wrap (ch_wrap)
    );

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.irq   = 1'b0;
        r_d.wr_en = 1'b0;

        // A completion seen while busy is parked with its data.
        if (adc_done && (r_q.state != ST_IDLE)) begin
            r_d.pend      = 1'b1;
            r_d.pend_data = adc_data;
        end

        unique case (r_q.state)
            ST_IDLE: begin
                if (r_q.pend) begin
                    r_d.state     = ST_REQ;
                    r_d.req       = 1'b1;
                    r_d.xfer_data = r_q.pend_data;
                    r_d.pend      = adc_done;
                    if (adc_done) begin
                        r_d.pend_data = adc_data;
                    end
                end else if (adc_done) begin
                    r_d.state     = ST_REQ;
                    r_d.req       = 1'b1;
                    r_d.xfer_data = adc_data;
                end else if (scan_start) begin
                    r_d.ch    = '0;
                    r_d.start = 1'b1;
                end
            end
            ST_REQ: begin
                if (bus_gnt) begin
                    r_d.state   = ST_WR_HI;
                    r_d.wr_en   = 1'b1;
                    r_d.wr_addr = addr_hi;
                    r_d.wr_data = r_q.xfer_data[RES_W-1:BYTE_W];
                end
            end
            ST_WR_HI: begin
                r_d.state   = ST_WR_LO;
                r_d.wr_en   = 1'b1;
                r_d.wr_addr = addr_lo;
                r_d.wr_data = r_q.xfer_data[BYTE_W-1:0];
            end
            ST_WR_LO: begin
                r_d.state = ST_IDLE;
                r_d.req   = 1'b0;
                r_d.ch    = ch_next;
                r_d.start = 1'b1;
                r_d.irq   = ch_wrap && cfg_irq_en;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign adc_ch    = r_q.ch;
    assign adc_start = r_q.start;
    assign bus_req   = r_q.req;
    assign wr_en     = r_q.wr_en;
    assign wr_addr   = r_q.wr_addr;
    assign wr_data   = r_q.wr_data;
    assign irq       = r_q.irq;
endmodule

// File: rtl/adc_scan_dma_chk.sv
module adc_scan_dma_chk #(
    parameter int ADDR_W = 12,
    parameter int CH_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_irq_en,
    input logic [CH_W-1:0]   adc_ch,
    input logic              adc_start,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              irq
);
    p_wr_inside_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> bus_req);

    p_wr_after_gnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> $past(bus_gnt));

    p_wr_second_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |=> (wr_en && wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

    p_wr_two_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |=> !wr_en);

    p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_en) |-> (!bus_req && adc_start));

    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_at_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (adc_start && adc_ch == '0));

    p_irq_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cfg_irq_en));
endmodule

bind adc_scan_dma adc_scan_dma_chk #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_irq_en (cfg_irq_en),
    .adc_ch     (adc_ch),
    .adc_start  (adc_start),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .irq        (irq)
);

// File: tb/adc_scan_dma_tb_top.sv
module adc_scan_dma_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int CH_W   = 3;
    localparam int BYTE_W = 8;
    localparam int WD_CYCLES = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [CH_W-1:0]   cfg_last_ch = '0;
    logic              cfg_irq_en = 1'b0;
    logic              scan_start = 1'b0;
    logic              adc_done = 1'b0;
    logic [15:0]       adc_data = '0;
    logic [CH_W-1:0]   adc_ch;
    logic              adc_start;
    logic              bus_req;
    logic              bus_gnt = 1'b0;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic              irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_scan_dma #(.ADDR_W(ADDR_W), .CH_W(CH_W), .BYTE_W(BYTE_W)) dut_i (
        .clk, .rst_n, .cfg_base, .cfg_last_ch, .cfg_irq_en, .scan_start,
        .adc_done, .adc_data, .adc_ch, .adc_start, .bus_req, .bus_gnt,
        .wr_en, .wr_addr, .wr_data, .irq
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Runs one transfer for input ch and checks every cycle of it.
    task automatic do_xfer(input logic [15:0] data, input int ch, input int gnt_wait,
                           input int next_ch, input bit exp_irq);
        logic [ADDR_W-1:0] a;
        a = cfg_base + ADDR_W'(2 * ch);
        adc_data = data; adc_done = 1'b1;
        step();
        adc_done = 1'b0;
        chk(bus_req == 1'b1, "R3 bus_req after done", 32'(bus_req), 1);
        for (int i = 0; i < gnt_wait; i++) begin
            chk(wr_en == 1'b0, "R3 no write before grant", 32'(wr_en), 0);
            step();
        end
        bus_gnt = 1'b1;
        step();
        chk(wr_en && wr_addr == a, "R4 high byte addr", 32'(wr_addr), 32'(a));
        chk(wr_data == data[15:8], "R4 high byte data", 32'(wr_data), 32'(data[15:8]));
        step();
        chk(wr_en && wr_addr == ADDR_W'(a + 1'b1), "R4 low byte addr",
            32'(wr_addr), 32'(ADDR_W'(a + 1'b1)));
        chk(wr_data == data[7:0], "R4 low byte data", 32'(wr_data), 32'(data[7:0]));
        step();
        bus_gnt = 1'b0;
        chk(!bus_req && !wr_en, "R5 release", 32'({bus_req, wr_en}), 0);
        chk(adc_start == 1'b1, "R6 start pulse", 32'(adc_start), 1);
        chk(adc_ch == CH_W'(next_ch), "R6 R7 next input", 32'(adc_ch), 32'(next_ch));
        chk(irq == exp_irq, "R7 R8 irq at release", 32'(irq), 32'(exp_irq));
        step();
        chk(!adc_start && !irq, "R6 R7 single pulse", 32'({adc_start, irq}), 0);
    endtask

    task automatic kick();
        scan_start = 1'b1;
        step();
        scan_start = 1'b0;
        chk(adc_start && adc_ch == 0, "R2 scan start", 32'({adc_start, adc_ch}), 32'h8);
        step();
        chk(adc_start == 1'b0, "R2 start single cycle", 32'(adc_start), 0);
    endtask

    task automatic t_reset();
        chk(!bus_req && !wr_en && !adc_start && !irq, "R1 outputs low",
            32'({bus_req, wr_en, adc_start, irq}), 0);
        chk(adc_ch == 0, "R1 input zero", 32'(adc_ch), 0);
    endtask

    task automatic t_scan_irq();
        cfg_base = 12'h100; cfg_last_ch = 3'd3; cfg_irq_en = 1'b1;
        kick();
        do_xfer(16'hA1B2, 0, 0, 1, 1'b0);
        do_xfer(16'h1357, 1, 3, 2, 1'b0);
        do_xfer(16'hFF00, 2, 1, 3, 1'b0);
        do_xfer(16'h0C0D, 3, 2, 0, 1'b1);   // R7 wrap with interrupt
        do_xfer(16'h4455, 0, 0, 1, 1'b0);   // scan restarts at input 0
    endtask

    task automatic t_no_irq();
        step();
        cfg_last_ch = 3'd0; cfg_irq_en = 1'b0;
        kick();
        do_xfer(16'h9876, 0, 1, 0, 1'b0);   // R8 wrap without interrupt
    endtask

    task automatic t_pending();
        step();
        cfg_base = 12'h040; cfg_last_ch = 3'd2; cfg_irq_en = 1'b1;
        kick();
        adc_data = 16'h1122; adc_done = 1'b1;
        step();
        adc_done = 1'b0;
        bus_gnt = 1'b1;
        step();
        chk(wr_en && wr_addr == 12'h040, "R9 first high", 32'(wr_addr), 32'h40);
        adc_data = 16'h3344; adc_done = 1'b1;   // arrives mid transfer
        step();
        adc_done = 1'b0; adc_data = 16'h0000;
        chk(wr_data == 8'h22, "R9 first low byte kept", 32'(wr_data), 32'h22);
        step();
        bus_gnt = 1'b0;
        chk(!bus_req && adc_ch == 1, "R9 release", 32'({bus_req, adc_ch}), 32'h1);
        step();
        chk(bus_req == 1'b1, "R9 pending re-request", 32'(bus_req), 1);
        bus_gnt = 1'b1;
        step();
        chk(wr_en && wr_addr == 12'h042 && wr_data == 8'h33, "R9 pending high",
            32'({wr_addr, wr_data}), 32'h04233);
        step();
        chk(wr_en && wr_addr == 12'h043 && wr_data == 8'h44, "R9 pending low",
            32'({wr_addr, wr_data}), 32'h04344);
        step();
        bus_gnt = 1'b0;
        chk(!bus_req && adc_ch == 2, "R9 second release", 32'({bus_req, adc_ch}), 32'h2);
        step();
        chk(bus_req == 1'b0, "R9 nothing else pending", 32'(bus_req), 0);
    endtask

    task automatic t_addr_wrap();
        step();
        cfg_base = 12'hFFE; cfg_last_ch = 3'd1; cfg_irq_en = 1'b1;
        kick();
        do_xfer(16'h5A5A, 0, 0, 1, 1'b0);
        do_xfer(16'hC3E1, 1, 0, 0, 1'b1);   // R10 slot 1 lands at 0x000
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_scan_irq();
        t_no_irq();
        t_pending();
        t_addr_wrap();
        repeat (2) step();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule